// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Controller

This block turns three Hall sensor levels, a direction bit, a PWM level and an active-low brake into six gate enables, one high-side and one low-side enable for each of the three motor phases. Each valid Hall code selects a six-step pattern. In that pattern one phase is switched with complementary PWM, one phase holds its low side on, and one phase floats. The direction bit swaps the roles of the switched phase and the held-low phase.

Each half-bridge has its own dead-time counter, and every turn-on waits until the bridge has been fully off for a shared, clamped number of cycles. After every change of Hall code, the phase about to be switched is first forced low for a fixed number of cycles. This refreshes its bootstrap supply even at full duty. A global enable from the fault manager kills all six gates within the same cycle. A one-cycle strobe marks every gate change so that current-sense blanking windows can follow it. All inputs are assumed to be synchronized to `clk` already.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir`=1, the Hall code `{hall[2],hall[1],hall[0]}` = {A,B,C} selects the phase roles (switched, held-low, floating) as follows: 101 gives A switched, C low, B floating. 100 gives B switched, C low, A floating. 110 gives B switched, A low, C floating. 010 gives C switched, A low, B floating. 011 gives C switched, B low, A floating. 001 gives A switched, B low, C floating. In the gate vectors, bit 2 is phase A, bit 1 is phase B and bit 0 is phase C.
- R2: With `dir`=0, the same codes give the same table with the switched phase and the held-low phase exchanged.
- R3: In steady state, the switched phase drives its high gate equal to `pwm` and its low gate equal to `!pwm`. The held-low phase keeps only its low gate on, and the floating phase has both gates off. Gate outputs are registered, one clock after the inputs.
- R4: No phase ever has its high gate and its low gate on in the same cycle.
- R5: A gate turns on only after both gates of its phase have been off for at least DT_EFF = max(`DT_CYC`, `MIN_DT_CYC`) cycles. When a request moves directly from one gate to the other, the gap is exactly DT_EFF cycles.
- R6: While `brake_n` is low, all high gates are off and, after dead time, all low gates are on, whatever `pwm` and `hall` are.
- R7: Hall codes 000 and 111 turn all six gates off one clock later.
- R8: While `enable` is low, all six gates are off in the same cycle, without waiting for a clock edge or for dead time.
- R9: When `hall` changes, the newly switched phase has its low gate on for exactly `PRE_CYC` cycles, starting one clock after the change, with its high gate off. Normal drive resumes after dead time, and this holds even when `pwm` is 1.
- R10: `sw_strobe` is 1 in exactly those cycles in which any gate output differs from its value in the previous cycle.
- R11: While `rst_n` is low, all gates and `sw_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global drive enable from the fault manager |
| hall | input | 3 | Hall levels, bit 2 = A, bit 1 = B, bit 0 = C |
| dir | input | 1 | Rotation direction |
| pwm | input | 1 | PWM level for the switched phase |
| brake_n | input | 1 | Active-low brake |
| gate_hi | output | 3 | High-side gate enables, bit 2 = A |
| gate_lo | output | 3 | Low-side gate enables, bit 2 = A |
| sw_strobe | output | 1 | One-cycle pulse on any gate change |

## Verification
Some rules hold on every cycle and can be checked continuously: no phase has both gates on, every turn-on is preceded by the full dead-time run of both gates off, a low enable clears all gates, brake clears the high side, and an invalid code clears everything. Other behaviour only the directed scenarios can show. These are the full decode table in both directions and both PWM levels, the exact length of the bootstrap pulse after a Hall edge, the exact dead-time gap including the clamped setting, and the cycle placement of the strobe.

// File: rtl/bldc_pkg.sv
// Shared types for the commutation controller.
package bldc_pkg;
    // Role a phase plays in the current commutation step.
    typedef enum logic [1:0] {
        PH_FLOAT  = 2'b00,
        PH_SWITCH = 2'b01,
        PH_LOW    = 2'b10
    } phase_role_t;
endpackage

// File: rtl/bldc_hall_decode.sv
// Hall decoder: maps the Hall code and direction to a role per phase.
// Assumes synchronized inputs. Codes 000 and 111 make every phase float.
// Output index 2 = phase A, 1 = B, 0 = C.
module bldc_hall_decode
    import bldc_pkg::*;
(
    input  logic                    dir,
    input  logic [2:0]              hall,
    output phase_role_t [2:0]       role
);
    phase_role_t [2:0] fwd;

    // Forward-direction table lookup.
    always_comb begin
        case (hall)
            3'b101:  fwd = {PH_SWITCH, PH_FLOAT,  PH_LOW};
            3'b100:  fwd = {PH_FLOAT,  PH_SWITCH, PH_LOW};
            3'b110:  fwd = {PH_LOW,    PH_SWITCH, PH_FLOAT};
            3'b010:  fwd = {PH_LOW,    PH_FLOAT,  PH_SWITCH};
            3'b011:  fwd = {PH_FLOAT,  PH_LOW,    PH_SWITCH};
            3'b001:  fwd = {PH_SWITCH, PH_LOW,    PH_FLOAT};
            default: fwd = {PH_FLOAT,  PH_FLOAT,  PH_FLOAT};
        endcase
    end

    // Reverse direction swaps the switched and held-low roles per phase.
    for (genvar g = 0; g < 3; g++) begin : g_dir
        always_comb begin
            if (dir || fwd[g] == PH_FLOAT)
                role[g] = fwd[g];
            else if (fwd[g] == PH_SWITCH)
                role[g] = PH_LOW;
            else
                role[g] = PH_SWITCH;
        end
    end
endmodule

// File: rtl/bldc_precharge.sv
// Bootstrap refresh timer: flags PRE_CYC cycles starting with the cycle in
// which the Hall code differs from the last sampled code.
// Assumes PRE_CYC >= 1.
module bldc_precharge #(
    parameter int PRE_CYC = 180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    output logic       pre_active
);
    localparam int PW = $clog2(PRE_CYC + 1);
    localparam logic [PW-1:0] LOAD = PW'(PRE_CYC - 1);

    logic [2:0]    hall_q;
    logic [PW-1:0] left;
    logic          edge_seen;

    // Detect a code change against the previous cycle.
    assign edge_seen  = (hall != hall_q);
    assign pre_active = edge_seen || (left != '0);

    // Track the last code and count down the remaining refresh cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hall_q <= 3'b000;
            left   <= '0;
        end else begin
            hall_q <= hall;
            if (edge_seen)
                left <= LOAD;
            else if (left != '0)
                left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/bldc_half_bridge.sv
// One half-bridge gate stage with dead-time interlock.
// A gate turns off at the next edge once its request drops. It turns on only
// after both gates have been off for DT_EFF cycles. A low enable forces both
// outputs off combinationally. Assumes rq_hi and rq_lo are never both set.
module bldc_half_bridge #(
    parameter int DT_EFF = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rq_hi,
    input  logic rq_lo,
    output logic out_hi,
    output logic out_lo
);
    localparam int CW = $clog2(DT_EFF + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(DT_EFF - 1);

    logic          hi_q;
    logic          lo_q;
    logic [CW-1:0] idle;
    logic          may_on;

    // The complementary gate has been off for long enough.
    assign may_on = (idle >= IDLE_MAX);

    // Gate state registers plus a saturating count of both-off cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
            idle <= '0;
        end else begin
            hi_q <= enable && rq_hi && (hi_q || (!lo_q && may_on));
            lo_q <= enable && rq_lo && (lo_q || (!hi_q && may_on));
            if (hi_q || lo_q)
                idle <= '0;
            else if (idle != IDLE_MAX)
                idle <= idle + 1'b1;
        end
    end

    // The enable kill bypasses the registers.
    assign out_hi = hi_q && enable;
    assign out_lo = lo_q && enable;
endmodule

// File: rtl/bldc_commutator.sv
// Six-step commutation controller: Hall decode, bootstrap refresh override,
// brake override, per-phase dead time and a gate-change strobe.
// Assumes all inputs are already synchronous to clk.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DT_CYC     = 100,
    parameter int MIN_DT_CYC = 3,
    parameter int PRE_CYC    = 180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [2:0] hall,
    input  logic       dir,
    input  logic       pwm,
    input  logic       brake_n,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       sw_strobe
);
    localparam int DT_EFF = (DT_CYC < MIN_DT_CYC) ? MIN_DT_CYC : DT_CYC;

    phase_role_t [2:0] role;
    logic              pre_active;
    logic [2:0]        rq_hi;
    logic [2:0]        rq_lo;
    logic [5:0]        gates_q;

    bldc_hall_decode u_decode (
        .dir  (dir),
        .hall (hall),
        .role (role)
    );

    bldc_precharge #(.PRE_CYC(PRE_CYC)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .hall       (hall),
        .pre_active (pre_active)
    );

    for (genvar g = 0; g < 3; g++) begin : g_phase
        // Gate request: brake first, then refresh override, then role.
        always_comb begin
            rq_hi[g] = 1'b0;
            rq_lo[g] = 1'b0;
            if (!brake_n) begin
                rq_lo[g] = 1'b1;
            end else begin
                case (role[g])
                    PH_SWITCH: begin
                        rq_hi[g] = pwm && !pre_active;
                        rq_lo[g] = !pwm || pre_active;
                    end
                    PH_LOW:  rq_lo[g] = 1'b1;
                    default: ;
                endcase
            end
        end

        bldc_half_bridge #(.DT_EFF(DT_EFF)) u_bridge (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .rq_hi  (rq_hi[g]),
            .rq_lo  (rq_lo[g]),
            .out_hi (gate_hi[g]),
            .out_lo (gate_lo[g])
        );
    end

    // Previous gate vector for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gates_q <= '0;
        else
            gates_q <= {gate_hi, gate_lo};
    end

    assign sw_strobe = ({gate_hi, gate_lo} != gates_q);
endmodule

// File: rtl/bldc_commutator_chk.sv
// Property checker for bldc_commutator, attached by bind.
// Keeps its own count of both-off cycles per phase to judge dead time.
module bldc_commutator_chk #(
    parameter int DT_EFF = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       brake_n,
    input logic [2:0] hall,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo
);
    localparam int W = $clog2(DT_EFF + 1);
    localparam logic [W-1:0] SAT = W'(DT_EFF);

    for (genvar g = 0; g < 3; g++) begin : g_chk
        logic [W-1:0] off_run;

        // Count consecutive cycles with both gates of this phase off.
        always_ff @(posedge clk) begin
            if (!rst_n)
                off_run <= '0;
            else if (gate_hi[g] || gate_lo[g])
                off_run <= '0;
            else if (off_run != SAT)
                off_run <= off_run + 1'b1;
        end

        a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[g] && gate_lo[g]));

        a_r5_hi_deadtime: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[g]) |-> off_run >= SAT);

        a_r5_lo_deadtime: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[g]) |-> off_run >= SAT);
    end

    a_r6_brake_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_n |=> gate_hi == 3'b000);

    a_r7_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_n && (hall == 3'b000 || hall == 3'b111))
        |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

    a_r8_enable_kill: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk #(.DT_EFF(DT_EFF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .brake_n (brake_n),
    .hall    (hall),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
);

// File: tb/bldc_commutator_test.sv
// Scoreboard bench: driver tasks queue expected gate vectors stamped with
// the cycle they must appear in; a negedge monitor compares and retires them.
module bldc_commutator_test;
    localparam int DT    = 4;
    localparam int MINDT = 2;
    localparam int PRE   = 6;
    localparam int DT2   = 2;   // clamped value for the second instance

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [2:0] hall = 3'b101;
    logic       dir = 1'b1;
    logic       pwm = 1'b1;
    logic       brake_n = 1'b1;
    logic [2:0] gate_hi, gate_lo, gate_hi2, gate_lo2;
    logic       sw_strobe, sw_strobe2;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit overlap_seen = 1'b0;

    typedef struct {
        int         stamp;
        int         inst;
        logic [2:0] hi;
        logic [2:0] lo;
        bit         chk_stb;
        logic       stb;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bldc_commutator #(.DT_CYC(DT), .MIN_DT_CYC(MINDT), .PRE_CYC(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hall(hall), .dir(dir),
        .pwm(pwm), .brake_n(brake_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sw_strobe(sw_strobe));

    bldc_commutator #(.DT_CYC(1), .MIN_DT_CYC(MINDT), .PRE_CYC(PRE)) uut_clamp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hall(hall), .dir(dir),
        .pwm(pwm), .brake_n(brake_n), .gate_hi(gate_hi2), .gate_lo(gate_lo2),
        .sw_strobe(sw_strobe2));

    // Role table from R1/R2: 2 bits per phase {A,B,C}, 01 switched, 10 low.
    function automatic logic [5:0] roles(logic [2:0] h, logic d);
        logic [5:0] r;
        case (h)
            3'b101:  r = 6'b01_00_10;
            3'b100:  r = 6'b00_01_10;
            3'b110:  r = 6'b10_01_00;
            3'b010:  r = 6'b10_00_01;
            3'b011:  r = 6'b00_10_01;
            3'b001:  r = 6'b01_10_00;
            default: r = 6'b00_00_00;
        endcase
        if (!d)
            for (int p = 0; p < 3; p++)
                if (r[2*p +: 2] != 2'b00) r[2*p +: 2] = ~r[2*p +: 2];
        return r;
    endfunction

    // Steady-state expectation from R3, R6, R7, R8.
    task automatic steady(output logic [2:0] hi, output logic [2:0] lo);
        logic [5:0] r;
        hi = 3'b000;
        lo = 3'b000;
        if (!enable) return;
        if (!brake_n) begin lo = 3'b111; return; end
        r = roles(hall, dir);
        for (int p = 0; p < 3; p++) begin
            if (r[2*p +: 2] == 2'b01) begin hi[p] = pwm; lo[p] = !pwm; end
            else if (r[2*p +: 2] == 2'b10) lo[p] = 1'b1;
        end
    endtask

    task automatic push(int st, int inst, logic [2:0] hi, logic [2:0] lo,
                        bit cs, logic stb, string tag);
        exp_t e;
        e.stamp = st; e.inst = inst; e.hi = hi; e.lo = lo;
        e.chk_stb = cs; e.stb = stb; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(logic [2:0] h, logic d, logic p, logic b, logic en);
        @(posedge clk); #2;
        hall = h; dir = d; pwm = p; brake_n = b; enable = en;
    endtask

    task automatic settle_check(string tag);
        logic [2:0] hi, lo;
        repeat (25) @(posedge clk);
        #2;
        steady(hi, lo);
        push(cyc, 0, hi, lo, 1'b1, 1'b0, tag);
        @(negedge clk); #1;
    endtask

    // Monitor: retire due items and record any overlap (R4).
    always @(negedge clk) begin
        int i;
        logic [2:0] ah, al;
        logic as;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].stamp <= cyc) begin
                ah = (sb[i].inst == 0) ? gate_hi : gate_hi2;
                al = (sb[i].inst == 0) ? gate_lo : gate_lo2;
                as = (sb[i].inst == 0) ? sw_strobe : sw_strobe2;
                n_checks++;
                if (sb[i].stamp != cyc || ah !== sb[i].hi || al !== sb[i].lo ||
                    (sb[i].chk_stb && as !== sb[i].stb)) begin
                    n_errors++;
                    $display("FAIL %s cyc=%0d inst=%0d: actual hi=%b lo=%b stb=%b expected hi=%b lo=%b stb=%b",
                             sb[i].tag, cyc, sb[i].inst, ah, al, as,
                             sb[i].hi, sb[i].lo, sb[i].stb);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
        if (rst_n && (((gate_hi & gate_lo) != 0) || ((gate_hi2 & gate_lo2) != 0)))
            overlap_seen = 1'b1;
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [2:0] codes [6];
        int k;
        codes = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

        // R11: reset state.
        repeat (3) @(posedge clk);
        #2;
        push(cyc, 0, 3'b000, 3'b000, 1'b1, 1'b0, "R11 reset");
        push(cyc, 1, 3'b000, 3'b000, 1'b0, 1'b0, "R11 reset clamp");
        @(negedge clk); #1;
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R1/R2/R3: every code, both directions, both PWM levels.
        for (int di = 1; di >= 0; di--)
            for (int ci = 0; ci < 6; ci++)
                for (int pv = 1; pv >= 0; pv--) begin
                    drive(codes[ci], di[0], pv[0], 1'b1, 1'b1);
                    settle_check(di != 0 ? "R1/R3 table dir=1" : "R2/R3 table dir=0");
                end

        // R7: invalid codes.
        drive(3'b000, 1'b1, 1'b1, 1'b1, 1'b1);
        settle_check("R7 code 000");
        drive(3'b111, 1'b1, 1'b1, 1'b1, 1'b1);
        settle_check("R7 code 111");

        // R6: brake with PWM high and a valid code.
        drive(3'b101, 1'b1, 1'b1, 1'b0, 1'b1);
        settle_check("R6 brake");

        // R8: enable low kills gates in the same cycle.
        drive(3'b101, 1'b1, 1'b1, 1'b1, 1'b1);
        settle_check("R3 before kill");
        drive(3'b101, 1'b1, 1'b1, 1'b1, 1'b0);
        push(cyc, 0, 3'b000, 3'b000, 1'b0, 1'b0, "R8 same-cycle kill");
        push(cyc, 1, 3'b000, 3'b000, 1'b0, 1'b0, "R8 same-cycle kill clamp");
        @(negedge clk); #1;
        drive(3'b101, 1'b1, 1'b1, 1'b1, 1'b1);
        settle_check("R8 re-enable");

        // R9: bootstrap refresh after a Hall edge 101 -> 100, PWM held high.
        drive(3'b100, 1'b1, 1'b1, 1'b1, 1'b1);
        k = cyc;
        for (int j = 1; j <= PRE; j++) begin
            push(k + j, 0, 3'b000, 3'b011, j <= 2, j == 1, "R9 refresh pulse");
            push(k + j, 1, 3'b000, 3'b011, 1'b0, 1'b0, "R9 refresh pulse clamp");
        end
        for (int j = 1; j <= DT; j++)
            push(k + PRE + j, 0, 3'b000, 3'b001, 1'b0, 1'b0, "R5 gap after refresh");
        push(k + PRE + DT + 1, 0, 3'b010, 3'b001, 1'b1, 1'b1, "R9 drive resumes");
        for (int j = 1; j <= DT2; j++)
            push(k + PRE + j, 1, 3'b000, 3'b001, 1'b0, 1'b0, "R5 clamped gap");
        push(k + PRE + DT2 + 1, 1, 3'b010, 3'b001, 1'b0, 1'b0, "R5 clamped turn-on");
        repeat (PRE + DT + 4) @(posedge clk);

        // R5/R10: PWM falls on switched phase B, low side after dead time.
        drive(3'b100, 1'b1, 1'b0, 1'b1, 1'b1);
        k = cyc;
        for (int j = 1; j <= DT; j++)
            push(k + j, 0, 3'b000, 3'b001, j <= 2, j == 1, "R5/R10 pwm fall gap");
        push(k + DT + 1, 0, 3'b000, 3'b011, 1'b1, 1'b1, "R5/R10 low side on");
        for (int j = 1; j <= DT2; j++)
            push(k + j, 1, 3'b000, 3'b001, 1'b0, 1'b0, "R5 clamped fall gap");
        push(k + DT2 + 1, 1, 3'b000, 3'b011, 1'b0, 1'b0, "R5 clamped low on");
        repeat (DT + 4) @(posedge clk);

        // R5: PWM rises again, high side after dead time.
        drive(3'b100, 1'b1, 1'b1, 1'b1, 1'b1);
        k = cyc;
        for (int j = 1; j <= DT; j++)
            push(k + j, 0, 3'b000, 3'b001, 1'b0, 1'b0, "R5 pwm rise gap");
        push(k + DT + 1, 0, 3'b010, 3'b001, 1'b1, 1'b1, "R5/R10 high side on");
        repeat (DT + 4) @(posedge clk);

        // R4: no overlap observed at any sample.
        n_checks++;
        if (overlap_seen) begin
            n_errors++;
            $display("FAIL R4 overlap: actual=seen expected=never");
        end
        n_checks++;
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL R3 scoreboard: actual=%0d pending expected=0", sb.size());
        end
        report();
    end
endmodule